// File: doc/BRIEF.md
# Dual-Issue In-Order Dispatch Controller

This block chooses, every cycle, which of the two oldest instruction-queue entries leave the queue. It also picks the execution unit that receives each one. The head entry (slot 0) and the one behind it (slot 1) each arrive with four fields: a valid flag, a unit class, a count of destination operands, and a multiply/divide flag for integer work.

Seven execution units report whether they can accept a new instruction: two integer units, float, load/store, system-register, vector permute and vector ALU. Two more inputs report the free rename registers and the free completion-queue entries.

The grants are combinational from the inputs of the current cycle. They feed three consumers:
- the instruction queue, through a pop count of 0, 1 or 2;
- the completion queue, through a push count;
- the rename allocator, through the number of registers to take.

Dispatch is strictly in order. Slot 1 is judged against the units and resources that remain after slot 0 has taken its share. Integer work is steered across the two asymmetric integer units, and only the first of them can multiply or divide.

Top module: `dual_dispatch_ctrl`

## Requirements
- R1: A slot whose valid flag is low is never granted. Only slot 0 and slot 1 are candidates.
- R2: Dispatch is in order: slot 1 is granted only in a cycle where slot 0 is also granted.
- R3: Unit indices are IU1=0, IU2=1, FPU=2, LSU=3, SRU=4, VPU=5 and VALU=6, and bit k of `unit_free_i` is unit k. A granted slot reports its target index, and a slot that is not granted reports 0. Two granted slots never share a unit.
- R4: Class codes are INT=0, FP=1, LS=2, SR=3, VP=4 and VA=5. A slot is granted only if its unit's free bit is set and the unit was not taken by slot 0. Class codes 6 and 7 are never granted.
- R5: Slot 0 needs `slot0_ndst_i <= ren_free_i`. Slot 1 needs `slot1_ndst_i <= ren_free_i - slot0_ndst_i`.
- R6: Slot 0 needs `cq_free_i >= 1`, and slot 1 needs `cq_free_i >= 2`.
- R7: An integer operation with the multiply/divide flag set may go only to IU1. A plain integer operation takes IU1 if IU1 is free, otherwise IU2. Slot 0 is steered before slot 1.
- R8: `iq_pop_o` and `cq_push_o` equal the number of grants. `ren_alloc_o` equals the sum of the destination counts of the granted slots.
- R9: While `rst_i` is high, no slot is granted and every count output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (used by the bound checks) |
| rst_i | input | 1 | Synchronous active-high reset; blocks all grants |
| slot0_vld_i | input | 1 | Head entry is valid |
| slot0_cls_i | input | 3 | Head entry unit class |
| slot0_ndst_i | input | DST_W | Head entry destination count |
| slot0_md_i | input | 1 | Head entry is integer multiply/divide |
| slot1_vld_i | input | 1 | Second entry is valid |
| slot1_cls_i | input | 3 | Second entry unit class |
| slot1_ndst_i | input | DST_W | Second entry destination count |
| slot1_md_i | input | 1 | Second entry is integer multiply/divide |
| unit_free_i | input | 7 | Per-unit vacancy flags |
| ren_free_i | input | REN_W | Free rename registers |
| cq_free_i | input | CQ_W | Free completion-queue entries |
| grant_o | output | 2 | Dispatch grant per slot |
| slot0_unit_o | output | 3 | Target unit of slot 0 |
| slot1_unit_o | output | 3 | Target unit of slot 1 |
| iq_pop_o | output | 2 | Entries to pop from the instruction queue |
| cq_push_o | output | 2 | Completion-queue entries to allocate |
| ren_alloc_o | output | REN_W | Rename registers to allocate |

## Verification
Two decisions often land in the same cycle: steering of integer work across the two integer units, and the resource gating that slot 1 sees after slot 0 has been charged. The table drives pairs in which both slots want integer units while IU1 is busy or the multiply flag sits on the second slot. It also drives pairs whose combined rename or completion needs exceed the supply by exactly one. Each such row is judged by the grant pair, by both unit indices and by the allocation counts, all sampled together.

// File: rtl/dd_pkg.sv
package dd_pkg;

  localparam int NUM_UNITS = 7;
  localparam int UNIT_W    = 3;
  localparam int CLS_W     = 3;
  localparam int NUM_SLOTS = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT = 3'd0,
    CLS_FP  = 3'd1,
    CLS_LS  = 3'd2,
    CLS_SR  = 3'd3,
    CLS_VP  = 3'd4,
    CLS_VA  = 3'd5
  } cls_e;

  typedef enum logic [UNIT_W-1:0] {
    U_IU1  = 3'd0,
    U_IU2  = 3'd1,
    U_FPU  = 3'd2,
    U_LSU  = 3'd3,
    U_SRU  = 3'd4,
    U_VPU  = 3'd5,
    U_VALU = 3'd6
  } unit_e;

  typedef struct packed {
    logic              found;
    logic [UNIT_W-1:0] idx;
  } pick_t;

  // Pick a target unit for one instruction among the still-free units.
  function automatic pick_t f_pick_unit(logic [CLS_W-1:0] cls, logic md,
                                        logic [NUM_UNITS-1:0] free);
    pick_t p;
    p = '{found: 1'b0, idx: '0};
    case (cls)
      CLS_INT: begin
        if (free[U_IU1])            p = '{found: 1'b1, idx: U_IU1};
        else if (!md && free[U_IU2]) p = '{found: 1'b1, idx: U_IU2};
      end
      CLS_FP:  if (free[U_FPU])  p = '{found: 1'b1, idx: U_FPU};
      CLS_LS:  if (free[U_LSU])  p = '{found: 1'b1, idx: U_LSU};
      CLS_SR:  if (free[U_SRU])  p = '{found: 1'b1, idx: U_SRU};
      CLS_VP:  if (free[U_VPU])  p = '{found: 1'b1, idx: U_VPU};
      CLS_VA:  if (free[U_VALU]) p = '{found: 1'b1, idx: U_VALU};
      default: p = '{found: 1'b0, idx: '0};
    endcase
    return p;
  endfunction

  function automatic logic [NUM_UNITS-1:0] f_onehot(logic [UNIT_W-1:0] idx);
    logic [NUM_UNITS-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_UNITS; k++) m[k] = (idx == UNIT_W'(k));
    return m;
  endfunction

endpackage

// File: rtl/dd_slot_eval.sv
module dd_slot_eval
  import dd_pkg::*;
#(
  parameter int DST_W = 2,
  parameter int REN_W = 6,
  parameter int CQ_W  = 5
) (
  input  logic                 go_in,
  input  logic                 vld,
  input  logic [CLS_W-1:0]     cls,
  input  logic [DST_W-1:0]     ndst,
  input  logic                 md,
  input  logic [NUM_UNITS-1:0] free_in,
  input  logic [REN_W-1:0]     ren_in,
  input  logic [CQ_W-1:0]      cq_in,
  output logic                 go,
  output logic [UNIT_W-1:0]    idx,
  output logic [NUM_UNITS-1:0] claim,
  output logic [NUM_UNITS-1:0] free_out,
  output logic [REN_W-1:0]     ren_out,
  output logic [CQ_W-1:0]      cq_out
);

  pick_t pick;
  logic  ren_fits;
  logic  cq_fits;

  always_comb begin
    pick     = f_pick_unit(cls, md, free_in);
    ren_fits = REN_W'(ndst) <= ren_in;
    cq_fits  = cq_in != '0;
    go       = go_in & vld & pick.found & ren_fits & cq_fits;
    idx      = go ? pick.idx : '0;
    claim    = go ? f_onehot(pick.idx) : '0;
    free_out = free_in & ~claim;
    ren_out  = go ? ren_in - REN_W'(ndst) : ren_in;
    cq_out   = go ? cq_in - CQ_W'(1) : cq_in;
  end

endmodule

// File: rtl/dd_grant_pack.sv
module dd_grant_pack
  import dd_pkg::*;
#(
  parameter int DST_W = 2,
  parameter int REN_W = 6
) (
  input  logic [NUM_SLOTS-1:0] go,
  input  logic [DST_W-1:0]     ndst0,
  input  logic [DST_W-1:0]     ndst1,
  output logic [1:0]           pop,
  output logic [1:0]           push,
  output logic [REN_W-1:0]     ren_alloc
);

  always_comb begin
    pop       = {1'b0, go[0]} + {1'b0, go[1]};
    push      = pop;
    ren_alloc = (go[0] ? REN_W'(ndst0) : '0) + (go[1] ? REN_W'(ndst1) : '0);
  end

endmodule

// File: rtl/dual_dispatch_ctrl.sv
module dual_dispatch_ctrl
  import dd_pkg::*;
#(
  parameter int DST_W = 2,
  parameter int REN_W = 6,
  parameter int CQ_W  = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 slot0_vld_i,
  input  logic [2:0]           slot0_cls_i,
  input  logic [DST_W-1:0]     slot0_ndst_i,
  input  logic                 slot0_md_i,
  input  logic                 slot1_vld_i,
  input  logic [2:0]           slot1_cls_i,
  input  logic [DST_W-1:0]     slot1_ndst_i,
  input  logic                 slot1_md_i,
  input  logic [6:0]           unit_free_i,
  input  logic [REN_W-1:0]     ren_free_i,
  input  logic [CQ_W-1:0]      cq_free_i,
  output logic [1:0]           grant_o,
  output logic [2:0]           slot0_unit_o,
  output logic [2:0]           slot1_unit_o,
  output logic [1:0]           iq_pop_o,
  output logic [1:0]           cq_push_o,
  output logic [REN_W-1:0]     ren_alloc_o
);

  logic                 s_vld  [NUM_SLOTS];
  logic [CLS_W-1:0]     s_cls  [NUM_SLOTS];
  logic [DST_W-1:0]     s_ndst [NUM_SLOTS];
  logic                 s_md   [NUM_SLOTS];

  logic                 ch_go   [NUM_SLOTS+1];
  logic [NUM_UNITS-1:0] ch_free [NUM_SLOTS+1];
  logic [REN_W-1:0]     ch_ren  [NUM_SLOTS+1];
  logic [CQ_W-1:0]      ch_cq   [NUM_SLOTS+1];

  logic [UNIT_W-1:0]    s_idx   [NUM_SLOTS];
  logic [NUM_UNITS-1:0] s_claim [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_go;

  // Named events for the checker.
  logic [NUM_UNITS-1:0] claim_mask;
  logic                 slot1_charged;

  always_comb begin
    s_vld[0]  = slot0_vld_i;  s_vld[1]  = slot1_vld_i;
    s_cls[0]  = slot0_cls_i;  s_cls[1]  = slot1_cls_i;
    s_ndst[0] = slot0_ndst_i; s_ndst[1] = slot1_ndst_i;
    s_md[0]   = slot0_md_i;   s_md[1]   = slot1_md_i;
    ch_go[0]   = ~rst_i;
    ch_free[0] = unit_free_i;
    ch_ren[0]  = ren_free_i;
    ch_cq[0]   = cq_free_i;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    dd_slot_eval #(.DST_W(DST_W), .REN_W(REN_W), .CQ_W(CQ_W)) u_eval (
      .go_in    (ch_go[s]),
      .vld      (s_vld[s]),
      .cls      (s_cls[s]),
      .ndst     (s_ndst[s]),
      .md       (s_md[s]),
      .free_in  (ch_free[s]),
      .ren_in   (ch_ren[s]),
      .cq_in    (ch_cq[s]),
      .go       (ch_go[s+1]),
      .idx      (s_idx[s]),
      .claim    (s_claim[s]),
      .free_out (ch_free[s+1]),
      .ren_out  (ch_ren[s+1]),
      .cq_out   (ch_cq[s+1])
    );
    assign slot_go[s] = ch_go[s+1];
  end

  assign claim_mask    = s_claim[0] | s_claim[1];
  assign slot1_charged = slot_go[1];

  dd_grant_pack #(.DST_W(DST_W), .REN_W(REN_W)) u_pack (
    .go        (slot_go),
    .ndst0     (slot0_ndst_i),
    .ndst1     (slot1_ndst_i),
    .pop       (iq_pop_o),
    .push      (cq_push_o),
    .ren_alloc (ren_alloc_o)
  );

  assign grant_o      = slot_go;
  assign slot0_unit_o = s_idx[0];
  assign slot1_unit_o = s_idx[1];

endmodule

// File: rtl/dd_checker.sv
module dd_checker #(
  parameter int DST_W = 2,
  parameter int REN_W = 6,
  parameter int CQ_W  = 5
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             slot0_vld_i,
  input logic [2:0]       slot0_cls_i,
  input logic [DST_W-1:0] slot0_ndst_i,
  input logic             slot0_md_i,
  input logic             slot1_vld_i,
  input logic [6:0]       unit_free_i,
  input logic [REN_W-1:0] ren_free_i,
  input logic [CQ_W-1:0]  cq_free_i,
  input logic [1:0]       grant_o,
  input logic [2:0]       slot0_unit_o,
  input logic [2:0]       slot1_unit_o,
  input logic [1:0]       iq_pop_o,
  input logic [REN_W-1:0] ren_alloc_o,
  input logic [6:0]       claim_mask,
  input logic             slot1_charged
);

  a_r1_invalid_slot0: assert property (@(posedge clk_i) disable iff (rst_i)
    !slot0_vld_i |-> !grant_o[0]);
  a_r1_invalid_slot1: assert property (@(posedge clk_i) disable iff (rst_i)
    !slot1_vld_i |-> !grant_o[1]);
  a_r2_in_order: assert property (@(posedge clk_i) disable iff (rst_i)
    slot1_charged |-> grant_o[0]);
  a_r3_distinct_units: assert property (@(posedge clk_i) disable iff (rst_i)
    (grant_o == 2'b11) |-> (slot0_unit_o != slot1_unit_o));
  a_r3_claims_match: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(claim_mask) == $countones(grant_o));
  a_r4_vacancy_slot0: assert property (@(posedge clk_i) disable iff (rst_i)
    grant_o[0] |-> unit_free_i[slot0_unit_o]);
  a_r4_vacancy_slot1: assert property (@(posedge clk_i) disable iff (rst_i)
    grant_o[1] |-> unit_free_i[slot1_unit_o]);
  a_r5_rename_budget: assert property (@(posedge clk_i) disable iff (rst_i)
    ren_alloc_o <= ren_free_i);
  a_r6_cq_budget: assert property (@(posedge clk_i) disable iff (rst_i)
    CQ_W'(iq_pop_o) <= cq_free_i);
  a_r7_muldiv_iu1: assert property (@(posedge clk_i) disable iff (rst_i)
    (grant_o[0] && slot0_cls_i == 3'd0 && slot0_md_i) |-> (slot0_unit_o == 3'd0));
  a_r9_reset_quiet: assert property (@(posedge clk_i)
    rst_i |-> (grant_o == 2'b00 && iq_pop_o == 2'd0));

endmodule

bind dual_dispatch_ctrl dd_checker #(.DST_W(DST_W), .REN_W(REN_W), .CQ_W(CQ_W)) u_chk (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .slot0_vld_i   (slot0_vld_i),
  .slot0_cls_i   (slot0_cls_i),
  .slot0_ndst_i  (slot0_ndst_i),
  .slot0_md_i    (slot0_md_i),
  .slot1_vld_i   (slot1_vld_i),
  .unit_free_i   (unit_free_i),
  .ren_free_i    (ren_free_i),
  .cq_free_i     (cq_free_i),
  .grant_o       (grant_o),
  .slot0_unit_o  (slot0_unit_o),
  .slot1_unit_o  (slot1_unit_o),
  .iq_pop_o      (iq_pop_o),
  .ren_alloc_o   (ren_alloc_o),
  .claim_mask    (claim_mask),
  .slot1_charged (slot1_charged)
);

// File: tb/test_dual_dispatch_ctrl.sv
module test_dual_dispatch_ctrl;

  logic       clk = 1'b0;
  logic       rst;
  logic       v0, m0, v1, m1;
  logic [2:0] c0, c1;
  logic [1:0] d0, d1;
  logic [6:0] fr;
  logic [5:0] ren;
  logic [4:0] cq;
  logic [1:0] grant, pop, push;
  logic [2:0] u0, u1;
  logic [5:0] ralloc;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dual_dispatch_ctrl i_dual_dispatch_ctrl (
    .clk_i(clk), .rst_i(rst),
    .slot0_vld_i(v0), .slot0_cls_i(c0), .slot0_ndst_i(d0), .slot0_md_i(m0),
    .slot1_vld_i(v1), .slot1_cls_i(c1), .slot1_ndst_i(d1), .slot1_md_i(m1),
    .unit_free_i(fr), .ren_free_i(ren), .cq_free_i(cq),
    .grant_o(grant), .slot0_unit_o(u0), .slot1_unit_o(u1),
    .iq_pop_o(pop), .cq_push_o(push), .ren_alloc_o(ralloc)
  );

  typedef struct packed {
    logic v0; logic [2:0] c0; logic [1:0] d0; logic m0;
    logic v1; logic [2:0] c1; logic [1:0] d1; logic m1;
    logic [6:0] fr; logic [5:0] ren; logic [4:0] cq;
    logic [1:0] eg; logic [2:0] eu0; logic [2:0] eu1;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    // R7: two plain INT, both IU free -> IU1, IU2
    '{1'b1,3'd0,2'd1,1'b0, 1'b1,3'd0,2'd1,1'b0, 7'h7F,6'd10,5'd8, 2'b11,3'd0,3'd1},
    // R7: mul on slot0, plain on slot1
    '{1'b1,3'd0,2'd1,1'b1, 1'b1,3'd0,2'd1,1'b0, 7'h7F,6'd10,5'd8, 2'b11,3'd0,3'd1},
    // R7: plain on slot0 takes IU1, mul on slot1 blocked
    '{1'b1,3'd0,2'd1,1'b0, 1'b1,3'd0,2'd1,1'b1, 7'h7F,6'd10,5'd8, 2'b01,3'd0,3'd0},
    // R7: IU1 busy, slot0 plain goes to IU2, slot1 nothing left
    '{1'b1,3'd0,2'd1,1'b0, 1'b1,3'd0,2'd1,1'b0, 7'h7E,6'd10,5'd8, 2'b01,3'd1,3'd0},
    // R7: IU1 busy, slot0 mul cannot use IU2
    '{1'b1,3'd0,2'd1,1'b1, 1'b1,3'd0,2'd1,1'b0, 7'h7E,6'd10,5'd8, 2'b00,3'd0,3'd0},
    // R3: FP + LS
    '{1'b1,3'd1,2'd1,1'b0, 1'b1,3'd2,2'd1,1'b0, 7'h7F,6'd10,5'd8, 2'b11,3'd2,3'd3},
    // R3: FP + FP share one unit
    '{1'b1,3'd1,2'd1,1'b0, 1'b1,3'd1,2'd1,1'b0, 7'h7F,6'd10,5'd8, 2'b01,3'd2,3'd0},
    // R1 R2: slot0 invalid
    '{1'b0,3'd1,2'd1,1'b0, 1'b1,3'd2,2'd1,1'b0, 7'h7F,6'd10,5'd8, 2'b00,3'd0,3'd0},
    // R1: slot1 invalid
    '{1'b1,3'd1,2'd1,1'b0, 1'b0,3'd2,2'd1,1'b0, 7'h7F,6'd10,5'd8, 2'b01,3'd2,3'd0},
    // R5: 2+2 with 3 free
    '{1'b1,3'd1,2'd2,1'b0, 1'b1,3'd2,2'd2,1'b0, 7'h7F,6'd3,5'd8, 2'b01,3'd2,3'd0},
    // R5: 2+2 with 4 free
    '{1'b1,3'd1,2'd2,1'b0, 1'b1,3'd2,2'd2,1'b0, 7'h7F,6'd4,5'd8, 2'b11,3'd2,3'd3},
    // R5: slot0 needs 3, 2 free
    '{1'b1,3'd1,2'd3,1'b0, 1'b1,3'd2,2'd0,1'b0, 7'h7F,6'd2,5'd8, 2'b00,3'd0,3'd0},
    // R6: one CQ entry
    '{1'b1,3'd1,2'd1,1'b0, 1'b1,3'd2,2'd1,1'b0, 7'h7F,6'd10,5'd1, 2'b01,3'd2,3'd0},
    // R6: no CQ entry
    '{1'b1,3'd1,2'd1,1'b0, 1'b1,3'd2,2'd1,1'b0, 7'h7F,6'd10,5'd0, 2'b00,3'd0,3'd0},
    // R6: two CQ entries
    '{1'b1,3'd1,2'd1,1'b0, 1'b1,3'd2,2'd1,1'b0, 7'h7F,6'd10,5'd2, 2'b11,3'd2,3'd3},
    // R4: SR + VP with VPU busy
    '{1'b1,3'd3,2'd1,1'b0, 1'b1,3'd4,2'd1,1'b0, 7'h5F,6'd10,5'd8, 2'b01,3'd4,3'd0},
    // R4: VA with VALU busy
    '{1'b1,3'd5,2'd1,1'b0, 1'b1,3'd1,2'd1,1'b0, 7'h3F,6'd10,5'd8, 2'b00,3'd0,3'd0},
    // R3: VP + VA
    '{1'b1,3'd4,2'd1,1'b0, 1'b1,3'd5,2'd2,1'b0, 7'h7F,6'd10,5'd8, 2'b11,3'd5,3'd6},
    // R5: zero-destination slot0 with no rename left, slot1 needs one
    '{1'b1,3'd1,2'd0,1'b0, 1'b1,3'd2,2'd1,1'b0, 7'h7F,6'd0,5'd2, 2'b01,3'd2,3'd0},
    // R4: undefined class 7
    '{1'b1,3'd7,2'd1,1'b0, 1'b1,3'd1,2'd1,1'b0, 7'h7F,6'd10,5'd8, 2'b00,3'd0,3'd0}
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t t);
    @(negedge clk);
    v0 = t.v0; c0 = t.c0; d0 = t.d0; m0 = t.m0;
    v1 = t.v1; c1 = t.c1; d1 = t.d1; m1 = t.m1;
    fr = t.fr; ren = t.ren; cq = t.cq;
    #1;
  endtask

  task automatic judge(vec_t t, string tag);
    int ng;
    int na;
    ng = int'(t.eg[0]) + int'(t.eg[1]);
    na = (t.eg[0] ? int'(t.d0) : 0) + (t.eg[1] ? int'(t.d1) : 0);
    chk({tag, " R2 grant"}, int'(grant), int'(t.eg));
    chk({tag, " R3 unit0"}, int'(u0), int'(t.eu0));
    chk({tag, " R3 unit1"}, int'(u1), int'(t.eu1));
    chk({tag, " R8 pop"},   int'(pop),  ng);
    chk({tag, " R8 push"},  int'(push), ng);
    chk({tag, " R8 alloc"}, int'(ralloc), na);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(VT[0]);
    // R9: reset blocks a dispatch that would otherwise be two-wide
    chk("R9 reset grant", int'(grant), 0);
    chk("R9 reset pop", int'(pop), 0);
    chk("R9 reset alloc", int'(ralloc), 0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      judge(VT[i], $sformatf("vec%0d", i));
    end
    // R9: reset asserted mid-run with a grantable pair
    drive(VT[5]);
    rst = 1'b1;
    #1;
    chk("R9 midrun grant", int'(grant), 0);
    chk("R9 midrun push", int'(push), 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    judge(VT[5], "after reset");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule